// File: doc/BRIEF.md
# Scaled Shift-and-Add Unit

This execution unit forms a scaled sum in one pipeline stage. It takes a 32-bit instruction word and two 64-bit unsigned source operands, A and B. It shifts B left by one to four places and adds A. The result is registered and comes out one clock after the request, together with the destination register index taken from the instruction.

The unit has two variants, and the instruction's extended opcode picks between them:

- **Full variant:** all 64 bits of B are scaled.
- **Word variant:** only the low 32 bits of B are used, zero-extended, before scaling. This serves address generation, where a 64-bit base is added to a 32-bit index or offset.

The sum wraps modulo 2^64. Register-file access, exceptions and flag updates belong to the surrounding pipeline.

The reset `rst_n` is active low and asserts asynchronously. The surrounding logic releases it synchronously to `clk`.

Top module: `ssa_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `out_valid` is 0.
- R2: The shift-select field is `in_insn[10:9]`. The left shift applied to B is that field plus one, so the value 0 scales by 2 and the value 3 scales by 16.
- R3: Full variant: `out_result = (B << shift) + A` modulo 2^64. Bits shifted past bit 63 and the carry out of the add are dropped.
- R4: Word variant: only `in_src_b[31:0]` enters the shift, zero-extended. `in_src_b[63:32]` has no effect on the result.
- R5: The extended opcode is `in_insn[8:1]`. The value `XO_FULL` (default 8'h6E) selects the full variant, and the value `XO_WORD` (default 8'h6F) selects the word variant.
- R6: A request whose extended opcode matches neither value raises no `out_valid`, and it leaves `out_result` and `out_rt` unchanged.
- R7: A recognised request with `in_valid` high at a clock edge makes `out_valid` high, and loads `out_result` and `out_rt`, in the cycle right after that edge. `out_valid` is 0 after a cycle with no recognised request.
- R8: `out_rt` carries the destination field `in_insn[25:21]` of the request that produced the result.
- R9: The following instruction bits do not change the result or `out_rt`: the primary opcode `in_insn[31:26]`, the source index fields `in_insn[20:11]`, and `in_insn[0]`.
- R10: When no recognised request is accepted, `out_result` and `out_rt` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| in_valid | input | 1 | Request present this cycle |
| in_insn | input | 32 | Instruction word (LSB-0 numbering) |
| in_src_a | input | 64 | Addend operand A |
| in_src_b | input | 64 | Scaled operand B |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_result | output | 64 | Registered scaled sum |
| out_rt | output | 5 | Destination register index of the result |

## Verification
A wrong shift-select decode or a wrong operand mask would corrupt `out_result` in the very next cycle after the request. The bench sees this on the first directed operation that uses each shift value with a nonzero upper half of B. A wrong extended-opcode decode shows up either as a missing or spurious `out_valid`, or as the wrong variant's sum, in the same one-cycle window. A broken load enable appears as a changed `out_result` one cycle after an unrecognised or idle cycle.

// File: rtl/ssa_pkg.sv
package ssa_pkg;
  localparam int INSN_W  = 32;
  localparam int REGIX_W = 5;
  localparam int XO_W    = 8;

  typedef enum logic {
    MODE_FULL = 1'b0,
    MODE_WORD = 1'b1
  } ssa_mode_e;
endpackage

// File: rtl/ssa_decode.sv
module ssa_decode
  import ssa_pkg::*;
#(
  parameter int                SEL_W   = 2,
  parameter logic [XO_W-1:0]   XO_FULL = 8'h6E,
  parameter logic [XO_W-1:0]   XO_WORD = 8'h6F
) (
  input  logic [INSN_W-1:0]  insn,
  output logic [REGIX_W-1:0] rt,
  output logic [SEL_W-1:0]   sel,
  output ssa_mode_e          mode,
  output logic               hit
);
  // Field positions, expressed in LSB-0 numbering of the 32-bit word.
  localparam int RT_LSB  = INSN_W - 6 - REGIX_W;   // 21
  localparam int SEL_LSB = INSN_W - 21 - SEL_W;    // 9
  localparam int XO_LSB  = 1;

  logic [XO_W-1:0] xo;
  logic            is_full;
  logic            is_word;
  logic            ign_unused;

  assign rt  = insn[RT_LSB +: REGIX_W];
  assign sel = insn[SEL_LSB +: SEL_W];
  assign xo  = insn[XO_LSB +: XO_W];

  always_comb begin
    is_full = (xo == XO_FULL);
    is_word = (xo == XO_WORD);
    hit     = is_full | is_word;
    mode    = is_word ? MODE_WORD : MODE_FULL;
  end

  // Opcode, source index fields and the last bit play no part here.
  assign ign_unused = ^{insn[INSN_W-1:RT_LSB+REGIX_W], insn[RT_LSB-1:SEL_LSB+SEL_W], insn[0]};
endmodule

// File: rtl/ssa_operand.sv
module ssa_operand
  import ssa_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32
) (
  input  ssa_mode_e         mode,
  input  logic [XLEN-1:0]   src_b,
  output logic [XLEN-1:0]   opnd
);
  localparam int PAD_W = XLEN - WORD_W;

  always_comb begin
    if (mode == MODE_WORD) begin
      opnd = {{PAD_W{1'b0}}, src_b[WORD_W-1:0]};
    end else begin
      opnd = src_b;
    end
  end
endmodule

// File: rtl/ssa_scale.sv
module ssa_scale #(
  parameter int XLEN  = 64,
  parameter int SEL_W = 2
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [XLEN-1:0]  opnd,
  output logic [XLEN-1:0]  scaled
);
  localparam int N_SH = 1 << SEL_W;

  logic [XLEN-1:0] cand [N_SH];

  // One fixed-wiring candidate per shift amount (sel + 1), then a mux.
  for (genvar k = 0; k < N_SH; k++) begin : g_shift
    assign cand[k] = {opnd[XLEN-2-k:0], {(k+1){1'b0}}};
  end

  assign scaled = cand[sel];
endmodule

// File: rtl/ssa_unit.sv
module ssa_unit
  import ssa_pkg::*;
#(
  parameter int              XLEN    = 64,
  parameter int              WORD_W  = 32,
  parameter int              SEL_W   = 2,
  parameter logic [XO_W-1:0] XO_FULL = 8'h6E,
  parameter logic [XO_W-1:0] XO_WORD = 8'h6F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [31:0]        in_insn,
  input  logic [XLEN-1:0]    in_src_a,
  input  logic [XLEN-1:0]    in_src_b,
  output logic               out_valid,
  output logic [XLEN-1:0]    out_result,
  output logic [REGIX_W-1:0] out_rt
);
  localparam int MAX_SH  = 1 << SEL_W;
  localparam int TOP_LSB = WORD_W + MAX_SH;

  logic [REGIX_W-1:0] dec_rt;
  logic [SEL_W-1:0]   dec_sel;
  ssa_mode_e          dec_mode;
  logic               dec_hit;
  logic [XLEN-1:0]    opnd_b;
  logic [XLEN-1:0]    scaled_b;

  logic               valid_d, valid_q;
  logic               load_en;
  logic [XLEN-1:0]    result_d, result_q;
  logic [REGIX_W-1:0] rt_d, rt_q;

  ssa_decode #(
    .SEL_W   (SEL_W),
    .XO_FULL (XO_FULL),
    .XO_WORD (XO_WORD)
  ) u_decode (
    .insn (in_insn),
    .rt   (dec_rt),
    .sel  (dec_sel),
    .mode (dec_mode),
    .hit  (dec_hit)
  );

  ssa_operand #(
    .XLEN   (XLEN),
    .WORD_W (WORD_W)
  ) u_operand (
    .mode  (dec_mode),
    .src_b (in_src_b),
    .opnd  (opnd_b)
  );

  ssa_scale #(
    .XLEN  (XLEN),
    .SEL_W (SEL_W)
  ) u_scale (
    .sel    (dec_sel),
    .opnd   (opnd_b),
    .scaled (scaled_b)
  );

  // Next-state logic
  always_comb begin
    load_en  = in_valid & dec_hit;
    valid_d  = load_en;
    result_d = scaled_b + in_src_a;
    rt_d     = dec_rt;
  end

  // Control register: reset to idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  // Data registers: enabled, no reset
  always_ff @(posedge clk) begin
    if (load_en) begin
      result_q <= result_d;
      rt_q     <= rt_d;
    end
  end

  assign out_valid  = valid_q;
  assign out_result = result_q;
  assign out_rt     = rt_q;

  // The smallest scale is 2, so the scaler output LSB is always clear.
  assert_scale_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (scaled_b[0] == 1'b0));

  // Word variant: nothing above bit WORD_W+MAX_SH may survive.
  assert_word_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_mode == MODE_WORD) |-> (scaled_b[XLEN-1:TOP_LSB] == '0));

  assert_word_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_mode == MODE_WORD) |-> (opnd_b[XLEN-1:WORD_W] == '0));

  assert_unknown_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec_hit) |=> !out_valid);

  assert_valid_lat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_hit) |=> out_valid);

  assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(in_valid && dec_hit)) |=> ($stable(out_result) && $stable(out_rt)));
endmodule

// File: tb/tb_ssa_unit.sv
module tb_ssa_unit;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_insn;
  logic [63:0] in_src_a;
  logic [63:0] in_src_b;
  logic        out_valid;
  logic [63:0] out_result;
  logic [4:0]  out_rt;

  localparam logic [7:0] XF = 8'h6E;
  localparam logic [7:0] XW = 8'h6F;

  int n_chk  = 0;
  int n_fail = 0;
  logic [63:0] last_res;
  logic [4:0]  last_rt;

  ssa_unit dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_insn    (in_insn),
    .in_src_a   (in_src_a),
    .in_src_b   (in_src_b),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_rt     (out_rt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rt,
                                     input logic [4:0] ra, input logic [4:0] rb,
                                     input logic [1:0] sel, input logic [7:0] xo,
                                     input logic lb);
    return {op, rt, ra, rb, sel, xo, lb};
  endfunction

  function automatic logic [63:0] expect_sum(input logic word, input logic [1:0] sel,
                                             input logic [63:0] a, input logic [63:0] b);
    logic [63:0] bb;
    bb = word ? {32'd0, b[31:0]} : b;
    return (bb << (int'(sel) + 1)) + a;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Apply a request for one cycle; return at the following negedge with outputs settled.
  task automatic issue(input logic [31:0] insn, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_insn  = insn;
    in_src_a = a;
    in_src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_op(input string req, input logic word, input logic [1:0] sel,
                        input logic [4:0] rt, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] e;
    e = expect_sum(word, sel, a, b);
    issue(mk(6'd22, rt, 5'd3, 5'd4, sel, word ? XW : XF, 1'b0), a, b);
    chk({req, " R7 valid"}, {63'd0, out_valid}, 64'd1);
    chk(req, out_result, e);
    chk({req, " R8 rt"}, {59'd0, out_rt}, {59'd0, rt});
    last_res = e;
    last_rt  = rt;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; in_valid = 1'b0; in_insn = '0; in_src_a = '0; in_src_b = '0;
    last_res = '0; last_rt = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {63'd0, out_valid}, 64'd0);

    // Every shift value, both variants, B with a busy upper half
    for (int s = 0; s < 4; s++) begin
      run_op("R2 R3 full", 1'b0, 2'(s), 5'(s + 1), 64'h0000_0000_0000_1000, 64'hDEAD_BEEF_0000_0003);
      run_op("R2 R4 word", 1'b1, 2'(s), 5'(s + 9), 64'h0000_0000_0000_1000, 64'hDEAD_BEEF_0000_0003);
    end
    // Explicit scale values
    issue(mk(6'd0, 5'd1, 5'd0, 5'd0, 2'd0, XF, 1'b0), 64'd0, 64'd5);
    chk("R2 sel0 scales by 2", out_result, 64'd10);
    issue(mk(6'd0, 5'd1, 5'd0, 5'd0, 2'd3, XF, 1'b0), 64'd0, 64'd5);
    chk("R2 sel3 scales by 16", out_result, 64'd80);
    // Wrap and shift-out
    run_op("R3 carry wrap", 1'b0, 2'd0, 5'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
    chk("R3 carry wrap value", out_result, 64'd1);
    run_op("R3 shift-out", 1'b0, 2'd3, 5'd2, 64'd0, 64'h8000_0000_0000_0001);
    chk("R3 shift-out value", out_result, 64'h10);
    run_op("R4 upper ignored", 1'b1, 2'd3, 5'd2, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R4 masked value", out_result, 64'h0000_000F_FFFF_FFF0);
    // Variant select by extended opcode
    issue(mk(6'd0, 5'd7, 5'd0, 5'd0, 2'd1, XW, 1'b0), 64'd1, 64'h1_0000_0001);
    chk("R5 word opcode", out_result, 64'd5);
    issue(mk(6'd0, 5'd7, 5'd0, 5'd0, 2'd1, XF, 1'b0), 64'd1, 64'h1_0000_0001);
    chk("R5 full opcode", out_result, 64'h4_0000_0005);
    last_res = 64'h4_0000_0005; last_rt = 5'd7;
    // Ignored fields: opcode, source indices, last bit
    issue(mk(6'h3F, 5'd7, 5'd31, 5'd17, 2'd1, XF, 1'b1), 64'd1, 64'h1_0000_0001);
    chk("R9 ignored fields result", out_result, 64'h4_0000_0005);
    chk("R9 ignored fields rt", {59'd0, out_rt}, 64'd7);
    // Unrecognised extended opcode
    issue(mk(6'd0, 5'd30, 5'd0, 5'd0, 2'd2, 8'h00, 1'b0), 64'h1234, 64'h5678);
    chk("R6 no valid", {63'd0, out_valid}, 64'd0);
    chk("R6 result kept", out_result, last_res);
    chk("R6 rt kept", {59'd0, out_rt}, {59'd0, last_rt});
    // Idle cycles hold the result
    @(negedge clk);
    chk("R7 valid drops", {63'd0, out_valid}, 64'd0);
    chk("R10 hold result", out_result, last_res);
    chk("R10 hold rt", {59'd0, out_rt}, {59'd0, last_rt});

    // Random mix
    for (int i = 0; i < 300; i++) begin
      logic        w;
      logic [1:0]  s;
      logic [4:0]  r;
      logic [63:0] a, b;
      w = 1'($urandom);
      s = 2'($urandom);
      r = 5'($urandom);
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 10 == 0) a = 64'hFFFF_FFFF_FFFF_FFF0;
      run_op(w ? "R4 random word" : "R3 random full", w, s, r, a, b);
    end
    summary();
  end
endmodule